// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block tracks what each hardware thread's instruction fetch is doing and moves every thread to its next state once per clock. It takes four kinds of input. The first is sticky stall requests: each of four downstream stages can raise a block pulse and later an unblock pulse. The second is redirects: a commit-side squash, a decode-side squash and a commit-side hold that says the reorder buffer is still draining. The third is a global context-switch stall. The fourth is the instruction cache handshake: send with accept or refuse, retry, and response, each tagged with a thread number and a request tag.

Only one refused request can wait for a retry at a time. While that slot is occupied, the cache port is blocked for every thread. Responses that arrive for a request that is no longer wanted are discarded, and a one-cycle drop pulse reports each one. The block outputs each thread's state code, each thread's latest redirect value, the cache-blocked flag, the drop pulse and a stage-active flag that tells the pipeline whether fetch has work to do.

Top module: `fetch_status_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every thread is Running, no stall flag is set, the cache port is unblocked, no request is outstanding, redirects read zero and no drop is reported. State codes on `thread_state` (4 bits per thread, thread t at bits 4t+3..4t) are: Idle 0, Running 1, Squashing 2, Blocked 3, WaitResponse 4, WaitRetry 5, AccessComplete 6, TrapPending 7, QuiescePending 8.
- R2: Each thread keeps four sticky stall flags. Bit 4t+s of `stage_block`/`stage_unblock` belongs to thread t and stage s, with decode=0, rename=1, execute=2, commit=3. A block pulse sets the flag and an unblock pulse clears it. An unblock pulse on a flag that is clear, or in the same cycle as a block pulse on that flag, is illegal input.
- R3: A commit squash has the highest priority. In the next cycle the thread is Squashing and its redirect equals the commit redirect value, even if a decode squash arrives in the same cycle.
- R4: While the reorder-buffer-busy input of a thread is high (and there is no commit squash), the thread is held in Squashing.
- R5: A decode squash moves the thread to Squashing and loads the decode redirect only if the thread is not already Squashing. Otherwise the redirect is left unchanged.
- R6: If any stall flag of the thread (after this cycle's pulses) or the context-switch stall is set, the thread goes to Blocked, unless it is in WaitResponse or WaitRetry, where it stays.
- R7: With no squash, no busy hold and no stall, a Blocked or Squashing thread returns to Running in the next cycle.
- R8: A response is accepted only if its thread is in WaitResponse and its tag equals that thread's outstanding tag. Any other response makes `resp_dropped` high in the next cycle and changes no state.
- R9: An accepted response moves the thread to Blocked if a stall is active, and to AccessComplete otherwise. An AccessComplete thread becomes Running when its `fetch_turn` bit is high.
- R10: A send is taken only from a Running thread while the port is unblocked. A taken, accepted send moves the thread to WaitResponse. A taken, refused send moves it to WaitRetry, fills the retry slot and blocks the port. Sends made while the port is blocked are ignored.
- R11: A retry that succeeds moves the slot owner to WaitResponse with the slot's tag outstanding, and unblocks the port. A retry that is refused changes nothing.
- R12: Any entry into Squashing clears the thread's outstanding tag and empties the retry slot if the thread owns it. A later retry with an empty slot only unblocks the port.
- R13: `stage_active` is high exactly when some thread whose `thread_enable` bit is set is in Running, Squashing or AccessComplete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thread_enable | input | NT | Threads that count toward stage activity |
| stage_block | input | 4*NT | Block pulses, bit 4t+s |
| stage_unblock | input | 4*NT | Unblock pulses, bit 4t+s |
| ctx_stall | input | 1 | Context-switch stall, all threads |
| cmt_squash | input | NT | Commit squash per thread |
| cmt_rob_busy | input | NT | Reorder buffer still squashing per thread |
| cmt_redirect | input | NT*RDR_W | Commit redirect (PC, next PC, micro PC) per thread |
| dec_squash | input | NT | Decode squash per thread |
| dec_redirect | input | NT*RDR_W | Decode redirect per thread |
| fetch_turn | input | NT | Thread's fetch turn this cycle |
| ic_send_valid | input | 1 | Request sent to the cache |
| ic_send_tid | input | TID_W | Thread of the request |
| ic_send_tag | input | TAG_W | Tag of the request |
| ic_send_ok | input | 1 | Cache accepted the request |
| ic_retry_valid | input | 1 | Cache retry notice |
| ic_retry_ok | input | 1 | Resend on retry accepted |
| ic_resp_valid | input | 1 | Cache response |
| ic_resp_tid | input | TID_W | Thread of the response |
| ic_resp_tag | input | TAG_W | Tag of the response |
| thread_state | output | 4*NT | State code per thread |
| thread_redirect | output | NT*RDR_W | Last redirect loaded per thread |
| ic_blocked | output | 1 | Cache port blocked by the retry slot |
| resp_dropped | output | 1 | Previous cycle's response was discarded |
| stage_active | output | 1 | Fetch stage has work |

## Verification
The bench goes after the priority order between squash sources. A design that let a decode squash override a commit squash would show the wrong redirect, and one that re-squashed an already squashing thread would overwrite it. It checks that a stall cannot pull a thread out of WaitResponse; a design that got this wrong would strand the miss so that its response is dropped. Stale-tag responses, responses to idle threads and responses after a squash must raise the drop pulse without touching state. The retry slot is exercised with a refused retry, a send attempted while the port is blocked, and a squash of the slot owner followed by a retry, which must only unblock the port and must not revive the squashed thread into WaitResponse.

// File: rtl/fsc_pkg.sv
// Shared types for the fetch status controller.
// Assumes state codes are fixed, since other blocks decode them.
package fsc_pkg;
    typedef enum logic [3:0] {
        ST_IDLE       = 4'd0,
        ST_RUN        = 4'd1,
        ST_SQUASH     = 4'd2,
        ST_BLOCKED    = 4'd3,
        ST_WAIT_RESP  = 4'd4,
        ST_WAIT_RETRY = 4'd5,
        ST_FILL_DONE  = 4'd6,
        ST_TRAP       = 4'd7,
        ST_QUIESCE    = 4'd8
    } fetch_state_e;

    localparam int STALL_SRCS = 4;
    localparam int STATE_W    = 4;
endpackage

// File: rtl/fsc_stall_flags.sv
// Sticky per-thread stall flags, one per downstream stage.
// Assumes unblock is only pulsed on a set flag and never with block.
module fsc_stall_flags #(
    parameter int NT = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NT*fsc_pkg::STALL_SRCS-1:0] blk,
    input  logic [NT*fsc_pkg::STALL_SRCS-1:0] unblk,
    input  logic                            ctx_stall,
    output logic [NT-1:0]                   stall_any
);
    localparam int NB = NT * fsc_pkg::STALL_SRCS;

    logic [NB-1:0] flags_q;
    logic [NB-1:0] flags_nxt;

    // Apply this cycle's pulses to the stored flags.
    assign flags_nxt = (flags_q | blk) & ~unblk;

    // Hold the flags.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_nxt;
    end

    genvar t;
    generate
        for (t = 0; t < NT; t++) begin : g_thr
            // Reduce one thread's flags with the global stall.
            assign stall_any[t] = (|flags_nxt[t*fsc_pkg::STALL_SRCS +: fsc_pkg::STALL_SRCS]) | ctx_stall;
        end
        for (t = 0; t < NB; t++) begin : g_chk
            // R2: unblock only on a set flag and never with block
            p_unblock_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
                unblk[t] |-> (flags_q[t] && !blk[t]));
        end
    endgenerate
endmodule

// File: rtl/fsc_retry_slot.sv
// Global single-entry retry slot and cache-blocked flag.
// Assumes a refused send only occurs while the port is unblocked.
module fsc_retry_slot #(
    parameter int NT    = 2,
    parameter int TID_W = 1,
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             refuse,
    input  logic [TID_W-1:0] ref_tid,
    input  logic [TAG_W-1:0] ref_tag,
    input  logic             retry_valid,
    input  logic             retry_ok,
    input  logic [NT-1:0]    kill,
    output logic             cache_blocked,
    output logic [NT-1:0]    grant,
    output logic [TAG_W-1:0] grant_tag
);
    logic             slot_vld_q;
    logic [TID_W-1:0] slot_tid_q;
    logic [TAG_W-1:0] slot_tag_q;
    logic             blocked_q;
    logic             slot_live;

    // The slot is live unless its owner is squashed this cycle.
    assign slot_live = slot_vld_q && !kill[slot_tid_q];
    assign cache_blocked = blocked_q;
    assign grant_tag = slot_tag_q;

    genvar t;
    generate
        for (t = 0; t < NT; t++) begin : g_grant
            // A successful resend goes back to the owner.
            assign grant[t] = retry_valid && retry_ok && slot_live
                              && (slot_tid_q == TID_W'(t));
        end
    endgenerate

    // Fill, drain and kill the slot; track the blocked flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_vld_q <= 1'b0;
            slot_tid_q <= '0;
            slot_tag_q <= '0;
            blocked_q  <= 1'b0;
        end else if (refuse) begin
            slot_vld_q <= 1'b1;
            slot_tid_q <= ref_tid;
            slot_tag_q <= ref_tag;
            blocked_q  <= 1'b1;
        end else begin
            if (!slot_live) slot_vld_q <= 1'b0;
            if (retry_valid && (retry_ok || !slot_live)) begin
                slot_vld_q <= 1'b0;
                blocked_q  <= 1'b0;
            end
        end
    end

    // R10: a refused send blocks the port
    p_refuse_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        refuse |=> cache_blocked);
    // R11: a successful retry unblocks the port
    p_retry_frees_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_valid && retry_ok && !refuse) |=> !cache_blocked);
    // R12: an empty-slot retry unblocks the port
    p_empty_retry_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_valid && !slot_vld_q && !refuse) |=> !cache_blocked);
endmodule

// File: rtl/fsc_thread.sv
// Next-state logic for one thread's fetch status.
// Assumes a fixed priority: commit squash, reorder-buffer hold,
// decode squash, stall, recovery, then cache events.
module fsc_thread #(
    parameter int TAG_W = 4,
    parameter int RDR_W = 68
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmt_sq,
    input  logic             rob_busy,
    input  logic             dec_sq,
    input  logic [RDR_W-1:0] cmt_rdr,
    input  logic [RDR_W-1:0] dec_rdr,
    input  logic             stall,
    input  logic             send_v,
    input  logic             send_ok,
    input  logic [TAG_W-1:0] send_tag,
    input  logic             cache_blocked,
    input  logic             grant,
    input  logic [TAG_W-1:0] grant_tag,
    input  logic             resp_v,
    input  logic [TAG_W-1:0] resp_tag,
    input  logic             turn,
    output fsc_pkg::fetch_state_e state,
    output logic [RDR_W-1:0] redirect,
    output logic             kill,
    output logic             send_take,
    output logic             resp_take
);
    import fsc_pkg::*;

    fetch_state_e     st_q, st_nxt;
    logic [RDR_W-1:0] rdr_q;
    logic             tag_vld_q;
    logic [TAG_W-1:0] tag_q;
    logic             sig_chg, load_c, load_d;

    assign state    = st_q;
    assign redirect = rdr_q;

    // Pick the next state by the fixed priority order.
    always_comb begin
        st_nxt  = st_q;
        sig_chg = 1'b1;
        kill    = 1'b0;
        load_c  = 1'b0;
        load_d  = 1'b0;
        if (cmt_sq) begin
            st_nxt = ST_SQUASH; kill = 1'b1; load_c = 1'b1;
        end else if (rob_busy) begin
            st_nxt = ST_SQUASH; kill = 1'b1;
        end else if (dec_sq && st_q != ST_SQUASH) begin
            st_nxt = ST_SQUASH; kill = 1'b1; load_d = 1'b1;
        end else if (stall && st_q != ST_WAIT_RESP && st_q != ST_WAIT_RETRY) begin
            st_nxt = ST_BLOCKED;
        end else if (st_q == ST_BLOCKED || st_q == ST_SQUASH) begin
            st_nxt = ST_RUN;
        end else begin
            sig_chg = 1'b0;
        end
        resp_take = resp_v && !sig_chg && st_q == ST_WAIT_RESP
                    && tag_vld_q && tag_q == resp_tag;
        send_take = send_v && !sig_chg && st_q == ST_RUN && !cache_blocked;
        if (!sig_chg) begin
            if (resp_take)                     st_nxt = stall ? ST_BLOCKED : ST_FILL_DONE;
            else if (send_take)                st_nxt = send_ok ? ST_WAIT_RESP : ST_WAIT_RETRY;
            else if (grant)                    st_nxt = ST_WAIT_RESP;
            else if (turn && st_q == ST_FILL_DONE) st_nxt = ST_RUN;
        end
    end

    // Register state, redirect and the outstanding request tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_RUN;
            rdr_q     <= '0;
            tag_vld_q <= 1'b0;
            tag_q     <= '0;
        end else begin
            st_q <= st_nxt;
            if (load_c)      rdr_q <= cmt_rdr;
            else if (load_d) rdr_q <= dec_rdr;
            if (kill || resp_take) begin
                tag_vld_q <= 1'b0;
            end else if (send_take && send_ok) begin
                tag_vld_q <= 1'b1;
                tag_q     <= send_tag;
            end else if (grant && !sig_chg) begin
                tag_vld_q <= 1'b1;
                tag_q     <= grant_tag;
            end
        end
    end

    // R3: commit squash always lands in Squashing
    p_commit_squash_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_sq |=> st_q == ST_SQUASH);
    // R4: busy reorder buffer holds Squashing
    p_rob_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rob_busy |=> st_q == ST_SQUASH);
    // R6: a pending miss is not pulled out by a stall
    p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT_RESP && !cmt_sq && !rob_busy && !dec_sq && !resp_take)
        |=> st_q == ST_WAIT_RESP);
endmodule

// File: rtl/fetch_status_ctrl.sv
// Top of the per-thread fetch status controller: stall flags, one
// state machine per thread, the shared retry slot and activity flag.
// Assumes thread ids on the cache handshake are below NT.
module fetch_status_ctrl #(
    parameter int NT    = 2,
    parameter int TAG_W = 4,
    parameter int PC_W  = 32,
    parameter int UPC_W = 4,
    parameter int RDR_W = 2*PC_W + UPC_W,
    parameter int TID_W = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NT-1:0]         thread_enable,
    input  logic [NT*4-1:0]       stage_block,
    input  logic [NT*4-1:0]       stage_unblock,
    input  logic                  ctx_stall,
    input  logic [NT-1:0]         cmt_squash,
    input  logic [NT-1:0]         cmt_rob_busy,
    input  logic [NT*RDR_W-1:0]   cmt_redirect,
    input  logic [NT-1:0]         dec_squash,
    input  logic [NT*RDR_W-1:0]   dec_redirect,
    input  logic [NT-1:0]         fetch_turn,
    input  logic                  ic_send_valid,
    input  logic [TID_W-1:0]      ic_send_tid,
    input  logic [TAG_W-1:0]      ic_send_tag,
    input  logic                  ic_send_ok,
    input  logic                  ic_retry_valid,
    input  logic                  ic_retry_ok,
    input  logic                  ic_resp_valid,
    input  logic [TID_W-1:0]      ic_resp_tid,
    input  logic [TAG_W-1:0]      ic_resp_tag,
    output logic [NT*4-1:0]       thread_state,
    output logic [NT*RDR_W-1:0]   thread_redirect,
    output logic                  ic_blocked,
    output logic                  resp_dropped,
    output logic                  stage_active
);
    import fsc_pkg::*;

    fetch_state_e  st [NT];
    logic [NT-1:0] stall_any, kill, grant, send_take, resp_take;
    logic [TAG_W-1:0] grant_tag;
    logic          refuse, drop_q;

    fsc_stall_flags #(.NT(NT)) u_flags (
        .clk(clk), .rst_n(rst_n), .blk(stage_block), .unblk(stage_unblock),
        .ctx_stall(ctx_stall), .stall_any(stall_any)
    );

    // A taken send that the cache refused fills the retry slot.
    assign refuse = |(send_take & {NT{~ic_send_ok}});

    fsc_retry_slot #(.NT(NT), .TID_W(TID_W), .TAG_W(TAG_W)) u_slot (
        .clk(clk), .rst_n(rst_n), .refuse(refuse), .ref_tid(ic_send_tid),
        .ref_tag(ic_send_tag), .retry_valid(ic_retry_valid), .retry_ok(ic_retry_ok),
        .kill(kill), .cache_blocked(ic_blocked), .grant(grant), .grant_tag(grant_tag)
    );

    genvar t;
    generate
        for (t = 0; t < NT; t++) begin : g_thr
            fsc_thread #(.TAG_W(TAG_W), .RDR_W(RDR_W)) u_thr (
                .clk(clk), .rst_n(rst_n),
                .cmt_sq(cmt_squash[t]), .rob_busy(cmt_rob_busy[t]), .dec_sq(dec_squash[t]),
                .cmt_rdr(cmt_redirect[t*RDR_W +: RDR_W]),
                .dec_rdr(dec_redirect[t*RDR_W +: RDR_W]),
                .stall(stall_any[t]),
                .send_v(ic_send_valid && ic_send_tid == TID_W'(t)),
                .send_ok(ic_send_ok), .send_tag(ic_send_tag),
                .cache_blocked(ic_blocked), .grant(grant[t]), .grant_tag(grant_tag),
                .resp_v(ic_resp_valid && ic_resp_tid == TID_W'(t)),
                .resp_tag(ic_resp_tag), .turn(fetch_turn[t]),
                .state(st[t]), .redirect(thread_redirect[t*RDR_W +: RDR_W]),
                .kill(kill[t]), .send_take(send_take[t]), .resp_take(resp_take[t])
            );
            assign thread_state[t*4 +: 4] = st[t];
        end
    endgenerate

    // Report a response that no thread took.
    always_ff @(posedge clk) begin
        if (!rst_n) drop_q <= 1'b0;
        else        drop_q <= ic_resp_valid && !(|resp_take);
    end
    assign resp_dropped = drop_q;

    // Stage is active if an enabled thread has fetch work.
    always_comb begin
        stage_active = 1'b0;
        for (int i = 0; i < NT; i++) begin
            if (thread_enable[i] && (st[i] == ST_RUN || st[i] == ST_SQUASH
                                     || st[i] == ST_FILL_DONE))
                stage_active = 1'b1;
        end
    end

    // R8: a response to a thread not waiting is always dropped
    p_stale_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ic_resp_valid && st[ic_resp_tid] != ST_WAIT_RESP) |=> resp_dropped);
    // R10: no send is taken while the port is blocked
    p_no_send_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ic_blocked |-> !(|send_take));
endmodule

// File: tb/fetch_status_ctrl_tb.sv
module fetch_status_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 2;
    localparam int TAG_W = 4;
    localparam int RDR_W = 68;

    localparam logic [3:0] S_RUN = 4'd1, S_SQ = 4'd2, S_BLK = 4'd3,
                           S_WR = 4'd4, S_WRT = 4'd5, S_DONE = 4'd6;

    logic clk = 1'b0;
    logic rst_n;
    logic [NT-1:0] thread_enable;
    logic [NT*4-1:0] stage_block, stage_unblock;
    logic ctx_stall;
    logic [NT-1:0] cmt_squash, cmt_rob_busy, dec_squash, fetch_turn;
    logic [NT*RDR_W-1:0] cmt_redirect, dec_redirect;
    logic ic_send_valid, ic_send_ok, ic_retry_valid, ic_retry_ok, ic_resp_valid;
    logic [0:0] ic_send_tid, ic_resp_tid;
    logic [TAG_W-1:0] ic_send_tag, ic_resp_tag;
    logic [NT*4-1:0] thread_state;
    logic [NT*RDR_W-1:0] thread_redirect;
    logic ic_blocked, resp_dropped, stage_active;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fetch_status_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .thread_enable(thread_enable),
        .stage_block(stage_block), .stage_unblock(stage_unblock), .ctx_stall(ctx_stall),
        .cmt_squash(cmt_squash), .cmt_rob_busy(cmt_rob_busy), .cmt_redirect(cmt_redirect),
        .dec_squash(dec_squash), .dec_redirect(dec_redirect), .fetch_turn(fetch_turn),
        .ic_send_valid(ic_send_valid), .ic_send_tid(ic_send_tid), .ic_send_tag(ic_send_tag),
        .ic_send_ok(ic_send_ok), .ic_retry_valid(ic_retry_valid), .ic_retry_ok(ic_retry_ok),
        .ic_resp_valid(ic_resp_valid), .ic_resp_tid(ic_resp_tid), .ic_resp_tag(ic_resp_tag),
        .thread_state(thread_state), .thread_redirect(thread_redirect),
        .ic_blocked(ic_blocked), .resp_dropped(resp_dropped), .stage_active(stage_active)
    );

    task automatic chk(input string req, input logic [RDR_W-1:0] act, input logic [RDR_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_st(input string req, input int t, input logic [3:0] exp);
        chk(req, RDR_W'(thread_state[t*4 +: 4]), RDR_W'(exp));
    endtask

    task automatic idle();
        stage_block = '0; stage_unblock = '0; ctx_stall = 0;
        cmt_squash = '0; cmt_rob_busy = '0; dec_squash = '0; fetch_turn = '0;
        ic_send_valid = 0; ic_send_ok = 0; ic_retry_valid = 0; ic_retry_ok = 0;
        ic_resp_valid = 0; ic_send_tid = '0; ic_resp_tid = '0;
        ic_send_tag = '0; ic_resp_tag = '0;
    endtask

    // Advance one edge and leave inputs idle, outputs settled.
    task automatic tick();
        @(posedge clk); #1;
        idle();
    endtask

    task automatic send(input int t, input logic [3:0] tag, input logic ok);
        ic_send_valid = 1; ic_send_tid = 1'(t); ic_send_tag = tag; ic_send_ok = ok;
        tick();
    endtask

    task automatic resp(input int t, input logic [3:0] tag);
        ic_resp_valid = 1; ic_resp_tid = 1'(t); ic_resp_tag = tag;
        tick();
    endtask

    task automatic t_reset();
        chk_st("R1 t0 state", 0, S_RUN);
        chk_st("R1 t1 state", 1, S_RUN);
        chk("R1 blocked", RDR_W'(ic_blocked), 0);
        chk("R1 dropped", RDR_W'(resp_dropped), 0);
        chk("R1 redirect", thread_redirect[RDR_W-1:0], 0);
        chk("R13 active at reset", RDR_W'(stage_active), 1);
    endtask

    task automatic t_stall();
        stage_block[0] = 1; tick();             // decode stalls thread 0
        chk_st("R6 t0 blocked", 0, S_BLK);
        chk_st("R6 t1 unaffected", 1, S_RUN);
        tick();
        chk_st("R2 flag sticky", 0, S_BLK);
        stage_unblock[0] = 1; tick();
        chk_st("R7 unblock resumes", 0, S_RUN);
        stage_block[4+3] = 1; tick();           // commit stalls thread 1
        chk_st("R2 bit 4t+s", 1, S_BLK);
        stage_unblock[4+3] = 1; tick();
        chk_st("R7 t1 resumes", 1, S_RUN);
        ctx_stall = 1; tick();
        chk_st("R6 ctx stall t0", 0, S_BLK);
        chk_st("R6 ctx stall t1", 1, S_BLK);
        tick();
        chk_st("R7 after ctx", 0, S_RUN);
    endtask

    task automatic t_squash();
        cmt_squash[1] = 1; cmt_redirect[RDR_W +: RDR_W] = 68'hA_1111_2222_3333_4444;
        dec_squash[1] = 1; dec_redirect[RDR_W +: RDR_W] = 68'h5_5555_6666_7777_8888;
        tick();
        chk_st("R3 squashing", 1, S_SQ);
        chk("R3 commit wins", thread_redirect[RDR_W +: RDR_W], 68'hA_1111_2222_3333_4444);
        tick();
        chk_st("R7 squash ends", 1, S_RUN);
        cmt_squash[0] = 1; cmt_redirect[RDR_W-1:0] = 68'h1; tick();
        cmt_rob_busy[0] = 1; tick();
        chk_st("R4 held 1", 0, S_SQ);
        cmt_rob_busy[0] = 1; tick();
        chk_st("R4 held 2", 0, S_SQ);
        tick();
        chk_st("R4 released", 0, S_RUN);
        dec_squash[0] = 1; dec_redirect[RDR_W-1:0] = 68'hD1; tick();
        chk_st("R5 decode squash", 0, S_SQ);
        chk("R5 loads", thread_redirect[RDR_W-1:0], 68'hD1);
        dec_squash[0] = 1; dec_redirect[RDR_W-1:0] = 68'hD2; tick();
        chk("R5 ignored while squashing", thread_redirect[RDR_W-1:0], 68'hD1);
        chk_st("R5 then running", 0, S_RUN);
    endtask

    task automatic t_miss();
        send(0, 4'h5, 1);
        chk_st("R10 wait response", 0, S_WR);
        stage_block[0] = 1; tick();
        chk_st("R6 stall deferred in wait", 0, S_WR);
        resp(0, 4'h5);
        chk_st("R9 resp under stall", 0, S_BLK);
        chk("R8 match not dropped", RDR_W'(resp_dropped), 0);
        chk("R13 blocked inactive", RDR_W'(stage_active), 1);
        stage_unblock[0] = 1; tick();
        chk_st("R7 resume", 0, S_RUN);
        send(0, 4'h6, 1);
        resp(0, 4'h7);
        chk("R8 stale tag dropped", RDR_W'(resp_dropped), 1);
        chk_st("R8 state kept", 0, S_WR);
        resp(0, 4'h6);
        chk_st("R9 access complete", 0, S_DONE);
        chk("R8 drop clears", RDR_W'(resp_dropped), 0);
        tick();
        chk_st("R9 waits for turn", 0, S_DONE);
        fetch_turn[0] = 1; tick();
        chk_st("R9 turn to running", 0, S_RUN);
        resp(1, 4'h6);
        chk("R8 idle thread dropped", RDR_W'(resp_dropped), 1);
        chk_st("R8 t1 kept", 1, S_RUN);
    endtask

    task automatic t_retry();
        send(0, 4'h3, 0);
        chk_st("R10 wait retry", 0, S_WRT);
        chk("R10 port blocked", RDR_W'(ic_blocked), 1);
        send(1, 4'h2, 1);
        chk_st("R10 send ignored", 1, S_RUN);
        ic_retry_valid = 1; ic_retry_ok = 0; tick();
        chk("R11 refused retry keeps", RDR_W'(ic_blocked), 1);
        chk_st("R11 still retry", 0, S_WRT);
        ic_retry_valid = 1; ic_retry_ok = 1; tick();
        chk_st("R11 resent", 0, S_WR);
        chk("R11 unblocked", RDR_W'(ic_blocked), 0);
        resp(0, 4'h3);
        chk_st("R11 slot tag used", 0, S_DONE);
        fetch_turn[0] = 1; tick();
        chk_st("R9 back to run", 0, S_RUN);
    endtask

    task automatic t_squash_slot();
        send(1, 4'h9, 0);
        chk_st("R10 t1 retry", 1, S_WRT);
        cmt_squash[1] = 1; tick();
        chk_st("R12 squash owner", 1, S_SQ);
        chk("R12 still blocked", RDR_W'(ic_blocked), 1);
        tick();
        chk_st("R12 running", 1, S_RUN);
        ic_retry_valid = 1; ic_retry_ok = 1; tick();
        chk("R12 empty retry unblocks", RDR_W'(ic_blocked), 0);
        chk_st("R12 no revive", 1, S_RUN);
        send(0, 4'h4, 1);
        dec_squash[0] = 1; tick();
        chk_st("R12 miss squashed", 0, S_SQ);
        resp(0, 4'h4);
        chk("R12 late resp dropped", RDR_W'(resp_dropped), 1);
        chk_st("R12 running after", 0, S_RUN);
    endtask

    task automatic t_active();
        thread_enable = 2'b01;
        stage_block[1] = 1; tick();
        chk("R13 none enabled active", RDR_W'(stage_active), 0);
        thread_enable = 2'b11; #1;
        chk("R13 t1 enabled", RDR_W'(stage_active), 1);
        stage_unblock[1] = 1; tick();
        chk_st("R2 rename unblock", 0, S_RUN);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        idle();
        thread_enable = 2'b11;
        cmt_redirect = '0; dec_redirect = '0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_stall();
        t_squash();
        t_miss();
        t_retry();
        t_squash_slot();
        t_active();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule